// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small CPU core and decides which interrupt, if any, is taken next. Each source is declared at build time as either an event source or a level source. An event source latches a pending flag that stays set until it is served or cleared. A level source requests only while its input is high. Each source has its own enable, and a single global enable gates all of them. Among the enabled pending sources, the lowest-numbered one wins.

When an interrupt is accepted, the controller clears the global enable and clears the winner's flag. One cycle later it presents a one-cycle acknowledge together with the vector index. A return strobe from the CPU sets the global enable again. After a return, the controller holds off any new acceptance until the CPU reports that one more instruction has retired. A handler may set the global enable itself, which allows nested interrupts.

The sequencer has three states. ST_OPEN is the state in which an acceptance may happen. ST_ENTRY is the one cycle that drives the acknowledge. ST_SHADOW waits for a retired instruction after a return. The transitions are named as follows:
- ACCEPT: ST_OPEN to ST_ENTRY, on an acceptance.
- REOPEN: ST_ENTRY to ST_OPEN, when there is no return.
- RETURN: any state to ST_SHADOW, on the return strobe.
- RELEASE: ST_SHADOW to ST_OPEN, on the retired strobe when there is no return.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When several sources are enabled and pending, the lowest-numbered one wins. Its vector index is the source number plus one, and index 0 is never produced for an interrupt.
- R2: A source is accepted only when its own enable and the global enable are both set. `irq_req` is high exactly when the global enable is set and at least one enabled source is pending.
- R3: An acceptance clears the global enable at that clock edge. In the next cycle `irq_ack` is high for exactly one cycle, and `irq_vec` carries the winner's index during that cycle. At all other times `irq_vec` is 0.
- R4: `reti` sets the global enable. No acceptance happens in the `reti` cycle, or afterwards, until a cycle with `retired` high has completed.
- R5: The flag of an event source is set by a high input and stays set while the source is disabled or the global enable is off. It is served later in priority order.
- R6: An event flag is cleared by its own acceptance, and only the winner's flag is cleared, or by a write of 1 to its bit in `flag_clr`. A new event in the same cycle as a clear leaves the flag set.
- R7: A level source has no flag. If its input drops before the source is enabled, no interrupt is produced.
- R8: `gie_clr` blocks an acceptance in its own cycle and clears the global enable. It wins over `gie_set` in the same cycle.
- R9: `gie_set` inside a handler re-opens acceptance from the next cycle, so a nested interrupt can be taken.
- R10: Reset clears all flags and the global enable, enters ST_OPEN, and drives `irq_req`, `irq_ack` and `irq_vec` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Source inputs: events for event sources, levels for level sources |
| src_en | input | N_SRC | Per-source enables |
| flag_clr | input | N_SRC | Write-one-to-clear strobes for event flags |
| gie_set | input | 1 | Sets the global enable |
| gie_clr | input | 1 | Clears the global enable at once |
| reti | input | 1 | Return-from-interrupt strobe |
| retired | input | 1 | Instruction-retired strobe |
| irq_req | output | 1 | An enabled source is pending and the global enable is on |
| irq_vec | output | $clog2(N_SRC+1) | Vector index during the acknowledge, otherwise 0 |
| irq_ack | output | 1 | One-cycle pulse marking entry into a handler |

## Verification
The assertions assume that `reti` and `gie_set` are single-cycle strobes from a well-behaved CPU. They also assume that `src_in`, `src_en` and `flag_clr` change only between clock edges. The bench drives every input just after the falling edge and holds it for a full cycle, so each input is stable at the rising edge. `reti` is raised only while a handler is notionally active. The shadow check relies on the acknowledge lagging the acceptance by one cycle; no stimulus combines `reti` with a pending acceptance in a way that would break that ordering.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_SHADOW = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int                N_SRC      = 4,
    parameter logic [N_SRC-1:0]  EVENT_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [N_SRC-1:0] flag_clr,
    input  logic [N_SRC-1:0] take_clr,
    output logic [N_SRC-1:0] pending
);
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] flag_d;

    // New event wins over a clear in the same cycle (R6); level bits never hold a flag (R7)
    assign flag_d = ((flag_q & ~flag_clr & ~take_clr) | src_in) & EVENT_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_pend
        if (EVENT_MASK[i]) begin : g_event
            assign pending[i] = flag_q[i];
        end else begin : g_level
            assign pending[i] = src_in[i];
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 4,
    localparam int VEC_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0] active,
    output logic [N_SRC-1:0] grant,
    output logic [VEC_W-1:0] win_vec,
    output logic             any
);
    logic [N_SRC:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_chain
        assign grant[i]  = active[i] & ~seen[i];
        assign seen[i+1] = seen[i] | active[i];
    end

    assign any = seen[N_SRC];

    always_comb begin
        win_vec = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (active[i]) win_vec = VEC_W'(i + 1);
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_active,
    input  logic gie_set,
    input  logic gie_clr,
    input  logic reti,
    input  logic retired,
    output logic take,
    output logic gie,
    output logic ack
);
    seq_state_t state_q, state_d;

    always_comb begin
        take = (state_q == ST_OPEN) && gie && any_active && !gie_clr && !reti;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (reti) state_d = ST_SHADOW;
                       else if (take) state_d = ST_ENTRY;
            ST_ENTRY:  if (reti) state_d = ST_SHADOW;
                       else state_d = ST_OPEN;
            ST_SHADOW: if (!reti && retired) state_d = ST_OPEN;
            default:   state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gie <= 1'b0;
        else if (take)           gie <= 1'b0;
        else if (gie_clr)        gie <= 1'b0;
        else if (gie_set || reti) gie <= 1'b1;
    end

    always_comb begin
        ack = (state_q == ST_ENTRY);
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int               N_SRC      = 4,
    parameter logic [N_SRC-1:0] EVENT_MASK = 4'b0011,
    localparam int              VEC_W      = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] flag_clr,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             reti,
    input  logic             retired,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_ack
);
    logic [N_SRC-1:0] pending;
    logic [N_SRC-1:0] active;
    logic [N_SRC-1:0] grant;
    logic [N_SRC-1:0] take_clr;
    logic [VEC_W-1:0] win_vec;
    logic             any_active;
    logic             take;
    logic             gie;
    logic [VEC_W-1:0] vec_q;

    assign active   = pending & src_en;
    assign take_clr = take ? grant : '0;

    irq_src_bank #(.N_SRC(N_SRC), .EVENT_MASK(EVENT_MASK)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .flag_clr (flag_clr),
        .take_clr (take_clr),
        .pending  (pending)
    );

    irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
        .active  (active),
        .grant   (grant),
        .win_vec (win_vec),
        .any     (any_active)
    );

    irq_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_active (any_active),
        .gie_set    (gie_set),
        .gie_clr    (gie_clr),
        .reti       (reti),
        .retired    (retired),
        .take       (take),
        .gie        (gie),
        .ack        (irq_ack)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    vec_q <= '0;
        else if (take) vec_q <= win_vec;
        else           vec_q <= '0;
    end

    assign irq_vec = vec_q;
    assign irq_req = any_active & gie;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int N_SRC = 4,
    localparam int VEC_W = $clog2(N_SRC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gie_clr,
    input logic             reti,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack
);
    // R1
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (irq_vec != '0) && (int'(irq_vec) <= N_SRC));

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R3
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |-> irq_vec == '0);

    // R3
    entry_gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !irq_req);

    // R2
    ack_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(irq_req));

    // R8
    gie_clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !irq_ack);

    // R4
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti |-> ##2 !irq_ack);
endmodule

bind irq_vector_ctrl irq_ctrl_chk #(.N_SRC(N_SRC)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .gie_clr (gie_clr),
    .reti    (reti),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .irq_ack (irq_ack)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    typedef struct packed {
        logic [3:0] s_in;
        logic [3:0] en;
        logic [3:0] clr;
        logic       gset;
        logic       gclr;
        logic       rti;
        logic       ret;
        logic       e_req;
        logic       e_ack;
        logic [2:0] e_vec;
        logic [3:0] rq;
    } row_t;

    // Sources 0 and 1 are event sources, 2 and 3 are level sources; vector = source + 1
    localparam int NROWS = 25;
    localparam row_t TBL [NROWS] = '{
        '{4'b0001,4'b0000,4'b0000,1,0,0,0, 0,0,3'd0, 4'd5},  // R5 event latched while masked
        '{4'b0000,4'b0000,4'b0000,0,0,0,0, 0,0,3'd0, 4'd5},
        '{4'b0000,4'b0001,4'b0000,0,0,0,0, 1,1,3'd1, 4'd2},  // R2 enable -> taken
        '{4'b0000,4'b0001,4'b0000,0,0,0,0, 0,0,3'd0, 4'd3},  // R3 gie cleared, flag cleared
        '{4'b0010,4'b0011,4'b0000,0,0,0,0, 0,0,3'd0, 4'd3},
        '{4'b0000,4'b0011,4'b0000,0,0,1,0, 0,0,3'd0, 4'd4},  // R4 return
        '{4'b0000,4'b0011,4'b0000,0,0,0,0, 1,0,3'd0, 4'd4},  // R4 shadow
        '{4'b0000,4'b0011,4'b0000,0,0,0,1, 1,0,3'd0, 4'd4},  // R4 retire
        '{4'b0000,4'b0011,4'b0000,0,0,0,0, 1,1,3'd2, 4'd4},
        '{4'b0100,4'b0000,4'b0000,1,0,0,0, 0,0,3'd0, 4'd9},  // R9 gie set in handler
        '{4'b0000,4'b0100,4'b0000,0,0,0,0, 0,0,3'd0, 4'd7},  // R7 level gone: nothing
        '{4'b1100,4'b1100,4'b0000,0,0,0,0, 1,1,3'd3, 4'd1},  // R1 level priority
        '{4'b1000,4'b1100,4'b0000,1,0,0,0, 0,0,3'd0, 4'd9},
        '{4'b1000,4'b1100,4'b0000,0,1,0,0, 1,0,3'd0, 4'd8},  // R8 clear blocks at once
        '{4'b1000,4'b1100,4'b0000,1,0,0,0, 0,0,3'd0, 4'd8},
        '{4'b1000,4'b1100,4'b0000,0,0,0,0, 1,1,3'd4, 4'd9},  // R9 nested take
        '{4'b0011,4'b0000,4'b0000,1,0,0,0, 0,0,3'd0, 4'd5},
        '{4'b0000,4'b0011,4'b0000,0,0,0,0, 1,1,3'd1, 4'd1},  // R1 event priority
        '{4'b0000,4'b0011,4'b0000,1,0,0,0, 0,0,3'd0, 4'd6},
        '{4'b0000,4'b0011,4'b0000,0,0,0,0, 1,1,3'd2, 4'd6},  // R6 loser flag kept
        '{4'b0001,4'b0000,4'b0000,1,0,0,0, 0,0,3'd0, 4'd6},
        '{4'b0000,4'b0000,4'b0001,0,0,0,0, 0,0,3'd0, 4'd6},  // R6 write-one clear
        '{4'b0000,4'b0001,4'b0000,0,0,0,0, 0,0,3'd0, 4'd6},
        '{4'b0001,4'b0000,4'b0001,0,0,0,0, 0,0,3'd0, 4'd6},  // R6 event wins over clear
        '{4'b0000,4'b0001,4'b0000,0,0,0,0, 1,1,3'd1, 4'd6}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [NS-1:0] src_in, src_en, flag_clr;
    logic gie_set, gie_clr, reti, retired;
    logic irq_req, irq_ack;
    logic [2:0] irq_vec;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl #(.N_SRC(NS), .EVENT_MASK(4'b0011)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en),
        .flag_clr(flag_clr), .gie_set(gie_set), .gie_clr(gie_clr),
        .reti(reti), .retired(retired), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] si, input logic [3:0] en, input logic [3:0] cl,
                         input logic gs, input logic gc, input logic rt, input logic rd);
        @(negedge clk);
        src_in = si; src_en = en; flag_clr = cl;
        gie_set = gs; gie_clr = gc; reti = rt; retired = rd;
    endtask

    initial begin
        for (int w = 0; w < 5000; w++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        src_in = '0; src_en = '0; flag_clr = '0;
        gie_set = 0; gie_clr = 0; reti = 0; retired = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 req", {3'b0, irq_req}, 4'd0);
        check("R10 ack", {3'b0, irq_ack}, 4'd0);
        check("R10 vec", {1'b0, irq_vec}, 4'd0);

        for (int r = 0; r < NROWS; r++) begin
            drive(TBL[r].s_in, TBL[r].en, TBL[r].clr, TBL[r].gset, TBL[r].gclr, TBL[r].rti, TBL[r].ret);
            #1;
            check($sformatf("R%0d req row%0d", TBL[r].rq, r), {3'b0, irq_req}, {3'b0, TBL[r].e_req});
            @(posedge clk); #1;
            check($sformatf("R%0d ack row%0d", TBL[r].rq, r), {3'b0, irq_ack}, {3'b0, TBL[r].e_ack});
            check($sformatf("R%0d vec row%0d", TBL[r].rq, r), {1'b0, irq_vec}, {1'b0, TBL[r].e_vec});
        end

        // R8: clear wins over set in the same cycle
        drive(4'b1000, 4'b1000, 4'b0000, 1, 1, 0, 0);
        drive(4'b1000, 4'b1000, 4'b0000, 0, 0, 0, 0);
        #1;
        check("R8 clr over set req", {3'b0, irq_req}, 4'd0);

        // R10: reset mid-run drops flags and global enable
        drive(4'b0001, 4'b0000, 4'b0000, 1, 0, 0, 0);
        @(negedge clk);
        src_in = '0; gie_set = 0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        src_en = 4'b0001;
        #1;
        check("R10 gie after reset", {3'b0, irq_req}, 4'd0);
        drive(4'b0000, 4'b0001, 4'b0000, 1, 0, 0, 0);
        drive(4'b0000, 4'b0001, 4'b0000, 0, 0, 0, 0);
        #1;
        check("R10 flag after reset", {3'b0, irq_req}, 4'd0);
        @(posedge clk); #1;
        check("R10 no ack after reset", {3'b0, irq_ack}, 4'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule